// File: doc/BRIEF.md
# Soft-Start Reference Sequencer with Hiccup Restart

This block produces the digital code that a reference DAC turns into the set-point of a step-down regulator's error amplifier. It runs from the switching clock. Once the converter is enabled, it raises the code from zero to its top value one level at a time. Each level lasts a fixed number of switching cycles. When the top level has run its full time, the block reports that the output is in regulation.

An overcurrent flag that arrives while the output is in regulation starts a hiccup. The code drops to zero at once, stays at zero for one full ramp time, and then a new ramp begins from zero. Overcurrent flags that arrive during the ramp itself are left to the pulse-skipping limiter, and the sequencer ignores them.

A high inhibit input overrides everything else. It parks the block at zero with both flags low. When inhibit is released, a fresh ramp starts.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to idle. After that edge `ref_code` is 0 and `ramping` and `in_reg` are both low.
- R2: With `inhibit` low and the block idle, the next clock edge starts a ramp. After it, `ramping` is 1, `in_reg` is 0 and `ref_code` is 0.
- R3: During a ramp, `ref_code` holds each value for exactly STEP_CYC clock cycles (32 by default) and then rises by exactly one. It passes through every value from 0 to 2^CODE_W-1 (63 by default).
- R4: After the top code has been held for its full STEP_CYC cycles, `ramping` falls and `in_reg` rises on the same edge, and `ref_code` stays at its maximum. With the defaults this is 2048 edges after the ramp starts.
- R5: An `oc_fault` high at a clock edge while `in_reg` is 1 and `inhibit` is 0 makes `ref_code` 0 and clears `in_reg` and `ramping` after that edge.
- R6: After such a fault, the outputs stay at code 0 with both flags low for HOLD_CYC edges (2048 by default). The next edge then starts a new ramp at code 0, and the ramp follows R3 and R4.
- R7: `inhibit` high at a clock edge forces code 0 with both flags low after that edge, whatever the state before it (ramp, regulation or hold).
- R8: When `inhibit` falls, a new ramp starts with its step timer cleared. The first code change comes a full STEP_CYC cycles after the ramp starts.
- R9: An `oc_fault` pulse during a ramp has no effect. The code keeps its staircase timing and no hold period begins.
- R10: `ref_code` never goes above its maximum and never wraps. `ramping` and `in_reg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inhibit | input | 1 | High disables the sequencer and forces zero |
| oc_fault | input | 1 | Overcurrent flag from the current-sense block |
| ref_code | output | CODE_W | Reference DAC code |
| ramping | output | 1 | Soft-start ramp in progress |
| in_reg | output | 1 | Ramp finished; output in regulation |

## Verification
The hardest situation to reach is the end of the hiccup hold. The bench can only get there by first running a complete ramp into regulation, then firing one fault pulse, and then waiting out the whole hold period. The stimulus does exactly this and checks every cycle of the hold as well as the first cycle of the new ramp. It then repeats the path, this time cutting the hold short with inhibit. Every ramp is checked cycle by cycle against the step index, which the bench computes from the cycle count. This also shows that an overcurrent pulse during the ramp, and the timer clearing after inhibit, leave no trace on the staircase.

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 32,
  parameter int HOLD_CYC = STEP_CYC * (2 ** CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibit,
  input  logic              oc_fault,
  output logic [CODE_W-1:0] ref_code,
  output logic              ramping,
  output logic              in_reg
);

  localparam int TW = $clog2(STEP_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CODE_W-1:0] CODE_MAX  = '1;
  localparam logic [TW-1:0]     STEP_LAST = TW'(STEP_CYC - 1);
  localparam logic [HW-1:0]     HOLD_LAST = HW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_RAMP, S_REG, S_HOLD} st_t;

  st_t              st;
  logic [TW-1:0]    step_tmr;
  logic [HW-1:0]    hold_tmr;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk) begin
    if (!rst_n || inhibit) begin
      st       <= S_IDLE;
      code     <= '0;
      step_tmr <= '0;
      hold_tmr <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st       <= S_RAMP;
          code     <= '0;
          step_tmr <= '0;
        end
        S_RAMP: begin
          if (step_tmr == STEP_LAST) begin
            step_tmr <= '0;
            if (code == CODE_MAX) st <= S_REG;
            else                  code <= code + 1'b1;
          end else begin
            step_tmr <= step_tmr + 1'b1;
          end
        end
        S_REG: begin
          if (oc_fault) begin
            st       <= S_HOLD;
            code     <= '0;
            hold_tmr <= '0;
          end
        end
        S_HOLD: begin
          if (hold_tmr == HOLD_LAST) begin
            st       <= S_RAMP;
            step_tmr <= '0;
            hold_tmr <= '0;
          end else begin
            hold_tmr <= hold_tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ref_code = code;
  assign ramping  = (st == S_RAMP);
  assign in_reg   = (st == S_REG);

endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inhibit,
  input logic              oc_fault,
  input logic [CODE_W-1:0] ref_code,
  input logic              ramping,
  input logic              in_reg
);

  localparam logic [CODE_W-1:0] CMAX = '1;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_INHIBIT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (ref_code == '0 && !ramping && !in_reg)); // R7

  AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reg && oc_fault && !inhibit) |=> (ref_code == '0 && !in_reg && !ramping)); // R5

  AST_RAMP_FAULT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ramping && oc_fault && !inhibit) |=> (ramping || in_reg)); // R9

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (ramping && $past(ramping) && ref_code != $past(ref_code)) |->
      (ref_code == $past(ref_code) + 1'b1)); // R3

  AST_REG_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $rose(in_reg) |-> ($past(ramping) && $past(ref_code) == CMAX)); // R4

  AST_REG_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    in_reg |-> ref_code == CMAX); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramping && in_reg)); // R10

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(ref_code) == CMAX && !$past(inhibit) && !in_reg && ramping) |-> ref_code == CMAX); // R10

endmodule

bind softstart_seq softstart_seq_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
  localparam int CW = 6;
  localparam int SC = 32;
  localparam int RAMP_LEN = SC * (2 ** CW);
  localparam int HOLD_LEN = RAMP_LEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inhibit = 1'b1;
  logic oc_fault = 1'b0;
  logic [CW-1:0] ref_code;
  logic ramping, in_reg;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  softstart_seq u0 (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .oc_fault(oc_fault),
    .ref_code(ref_code), .ramping(ramping), .in_reg(in_reg)
  );

  function automatic logic [7:0] pk(input logic r, input logic g, input int c);
    return {r, g, 6'(c)};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {ramping, in_reg, ref_code};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act ramp=%0b reg=%0b code=%0d exp ramp=%0b reg=%0b code=%0d",
               req, $time, act[7], act[6], act[5:0], exp[7], exp[6], exp[5:0]);
    end
  endtask

  // Starts at the first negedge after the ramp was entered (0 ramp edges).
  task automatic ramp_sweep(input string tag, input int oc_at);
    for (int i = 0; i <= RAMP_LEN; i++) begin
      @(negedge clk);
      if (i == 0)             check({"R2/R8 ", tag}, pk(1, 0, 0));
      else if (i < RAMP_LEN)  check({"R3/R9 ", tag}, pk(1, 0, i / SC));
      else                    check({"R4 ", tag}, pk(0, 1, (2 ** CW) - 1));
      oc_fault = (i == oc_at);
    end
    oc_fault = 1'b0;
  endtask

  task automatic hold_sweep(input string tag, input int inh_at);
    oc_fault = 1'b1;
    for (int j = 0; j < HOLD_LEN; j++) begin
      @(negedge clk);
      oc_fault = 1'b0;
      check({"R5/R6 ", tag}, pk(0, 0, 0));
      if (j == inh_at) begin
        inhibit = 1'b1;
        @(negedge clk);
        check({"R7 hold ", tag}, pk(0, 0, 0));
        inhibit = 1'b0;
        return;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pk(0, 0, 0));
    inhibit = 1'b0;
    @(negedge clk);
    check("R1 still in reset", pk(0, 0, 0));
    inhibit = 1'b1;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 held off", pk(0, 0, 0));
    inhibit = 1'b0;
    ramp_sweep("first", -1);

    // R5 R6: hiccup and hold to completion, then full ramp
    hold_sweep("full", -1);
    ramp_sweep("after hold", -1);

    // R7 in regulation
    inhibit = 1'b1;
    @(negedge clk);
    check("R7 reg", pk(0, 0, 0));
    inhibit = 1'b0;

    // R9: faults during ramp ignored
    ramp_sweep("oc early", 0);
    inhibit = 1'b1;
    @(negedge clk);
    inhibit = 1'b0;
    ramp_sweep("oc mid", 1000);
    inhibit = 1'b1;
    @(negedge clk);
    inhibit = 1'b0;
    ramp_sweep("oc late", RAMP_LEN - 2);

    // R7 R8: inhibit mid ramp, then fresh ramp
    inhibit = 1'b1;
    @(negedge clk);
    inhibit = 1'b0;
    for (int i = 0; i <= 40; i++) begin
      @(negedge clk);
      check("R3 partial", pk(1, 0, i / SC));
    end
    inhibit = 1'b1;
    @(negedge clk);
    check("R7 ramp", pk(0, 0, 0));
    inhibit = 1'b0;
    ramp_sweep("after inhibit", -1);

    // R7 during hold, then R8 fresh ramp
    hold_sweep("cut", 500);
    ramp_sweep("after cut hold", -1);

    // R10: code stays at max in regulation
    repeat (100) begin
      @(negedge clk);
      check("R10 saturate", pk(0, 1, (2 ** CW) - 1));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule